// File: doc/BRIEF.md
# Transition Interrupt Unit

This unit watches a 24-bit digital input word, which may already have been debounced upstream. It raises an interrupt when a channel makes a transition that software has armed. Each channel has its own rising-arm bit and its own falling-arm bit, held in byte-wide registers with one byte per group of eight channels. Two global control bits gate rising detection and falling detection as a whole.

Every qualifying transition feeds one sticky edge flag. A second qualifying transition that arrives before software has cleared the first sets a sticky overflow flag. On the clock edge where the edge flag goes from clear to set, the unit copies the whole input word into a snapshot register. That copy then stays frozen until software clears the flag, so software can see which channels moved. The interrupt output combines the two flags, each under its own enable, behind a master output enable. Software drives the unit through a simple byte-wide register port: one write strobe and a combinational read.

Top module: `edge_irq_ctl`

## Requirements
- R1: After reset, all arm masks, the control register, both flags and the snapshot read as zero, and `irq` is low.
- R2: When control bit 3 is set and a channel's rising-arm bit (byte at 0x18 + channel/8) is set, a 0-to-1 change of that input sets status bit 0 on the next clock edge.
- R3: When control bit 4 is set and a channel's falling-arm bit (byte at 0x20 + channel/8) is set, a 1-to-0 change of that input sets status bit 0 on the next clock edge.
- R4: A transition on a channel whose arm bit is clear, or whose direction is disabled in control bits 3 and 4, leaves the status register unchanged.
- R5: A qualifying transition while the edge flag is set, and not being cleared in the same cycle, sets the overflow flag (status bit 1).
- R6: Writing to offset 0x07 clears the edge flag if bit 3 is 1 and the overflow flag if bit 2 is 1. Both may be cleared in the same write. If a qualifying transition lands in the same cycle as the clear, it leaves the edge flag set and does not set overflow.
- R7: Status bit 2 and `irq` both equal control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). Writing 0 to the control register at 0x15 forces `irq` low.
- R8: On the cycle where the edge flag goes from clear to set, the input word is copied to the snapshot (bytes 0x10 to 0x12, low byte first). The snapshot does not change while the flag stays set.
- R9: A read of offset 0x06 returns 0x27.
- R10: The arm bytes and the 5-bit control register at 0x15 read back as written. The status register is at 0x14. Every unmapped offset, and the clear offset, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 24 | Input word being watched |
| addr | input | 6 | Register byte offset |
| wr_en | input | 1 | Write strobe for `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The previous-sample register, the flags and the snapshot are all visible at the ports within one cycle. A stale previous sample shows up as a missed or phantom status bit on the edge after a transition. A wrong snapshot shows up on readback of 0x10 to 0x12. The bench runs a behavioural model beside the unit and compares `irq` and `rdata` every cycle, so a flag that sets or clears one cycle off is caught on that same cycle. It also applies a clear in the same cycle as a new transition, where the priority between clearing and setting decides the outcome.

// File: rtl/edge_irq_ctl.sv
module edge_irq_ctl #(
  parameter int NCH = 24,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic           irq
);
  localparam int NB = (NCH + 7) / 8;
  localparam int PW = NB * 8;
  localparam logic [AW-1:0] A_SNAP = AW'(8'h10);
  localparam logic [AW-1:0] A_ID   = AW'(8'h06);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h07);
  localparam logic [AW-1:0] A_STAT = AW'(8'h14);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h15);
  localparam logic [AW-1:0] A_RISE = AW'(8'h18);
  localparam logic [AW-1:0] A_FALL = AW'(8'h20);

  logic [PW-1:0] din_p, prev_q, rmask_q, fmask_q, snap_q;
  logic [4:0]    ctrl_q;
  logic          edge_q, ovf_q;

  always_comb begin
    din_p = '0;
    din_p[NCH-1:0] = din;
  end

  wire wr_clr   = wr_en && (addr == A_CLR);
  wire clr_edge = wr_clr && wdata[3];
  wire clr_ovf  = wr_clr && wdata[2];
  wire [PW-1:0] rise_hit = ~prev_q & din_p & rmask_q & {PW{ctrl_q[3]}};
  wire [PW-1:0] fall_hit = prev_q & ~din_p & fmask_q & {PW{ctrl_q[4]}};
  wire hit = |(rise_hit | fall_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      snap_q <= '0;
      ctrl_q <= '0;
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      prev_q <= din_p;
      edge_q <= hit | (edge_q & ~clr_edge);
      ovf_q  <= (hit & edge_q & ~clr_edge) | (ovf_q & ~clr_ovf);
      if (hit && (!edge_q || clr_edge)) snap_q <= din_p;
      if (wr_en && addr == A_CTRL) ctrl_q <= wdata[4:0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rmask_q[b*8 +: 8] <= '0;
        fmask_q[b*8 +: 8] <= '0;
      end else if (wr_en) begin
        if (addr == A_RISE + AW'(b)) rmask_q[b*8 +: 8] <= wdata;
        if (addr == A_FALL + AW'(b)) fmask_q[b*8 +: 8] <= wdata;
      end
    end
  end

  assign irq = ctrl_q[2] & ((edge_q & ctrl_q[0]) | (ovf_q & ctrl_q[1]));

  always_comb begin
    rdata = '0;
    if (addr == A_ID)   rdata = 8'h27;
    if (addr == A_STAT) rdata = {5'b0, irq, ovf_q, edge_q};
    if (addr == A_CTRL) rdata = {3'b0, ctrl_q};
    for (int b = 0; b < NB; b++) begin
      if (addr == A_SNAP + AW'(b)) rdata = snap_q[b*8 +: 8];
      if (addr == A_RISE + AW'(b)) rdata = rmask_q[b*8 +: 8];
      if (addr == A_FALL + AW'(b)) rdata = fmask_q[b*8 +: 8];
    end
  end
endmodule

// File: rtl/edge_irq_ctl_chk.sv
module edge_irq_ctl_chk #(
  parameter int AW = 6,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          irq,
  input logic          edge_q,
  input logic          ovf_q,
  input logic [PW-1:0] snap_q,
  input logic [PW-1:0] rmask_q,
  input logic [PW-1:0] fmask_q
);
  wire wclr = wr_en && addr == AW'(8'h07);
  wire idle = (rmask_q == '0) && (fmask_q == '0);

  a_r5_ovf_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(edge_q));
  a_r8_snap_held: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && !(wclr && wdata[3])) |=> $stable(snap_q));
  a_r6_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr && wdata[3] && idle) |=> !edge_q);
  a_r6_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr && wdata[2] && idle) |=> !ovf_q);
  a_r7_ctrl_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h15) && wdata[4:0] == 5'd0) |=> !irq);
  a_r9_id_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(8'h06)) |-> (rdata == 8'h27));
endmodule

bind edge_irq_ctl edge_irq_ctl_chk #(.AW(AW), .PW(PW)) u_chk (.*);

// File: tb/edge_irq_ctl_bench.sv
module edge_irq_ctl_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [23:0] din = '0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int vecs = 0, bad = 0, cyc = 0;
  bit live = 0, done = 0;

  always #10 clk = ~clk;

  edge_irq_ctl u_edge_irq_ctl (.clk, .rst_n, .din, .addr, .wr_en, .wdata, .rdata, .irq);

  int m_prev, m_rm, m_fm, m_ctrl, m_snap;
  bit m_edge, m_ovf;

  function automatic int m_irq();
    return ((m_ctrl >> 2) & 1) & (((m_edge & m_ctrl) & 1) | (m_ovf & ((m_ctrl >> 1) & 1)));
  endfunction

  function automatic int m_rd(int a);
    if (a == 6) return 'h27;
    if (a == 'h14) return m_edge | (m_ovf << 1) | (m_irq() << 2);
    if (a == 'h15) return m_ctrl;
    if (a >= 'h10 && a <= 'h12) return (m_snap >> (8*(a-'h10))) & 'hff;
    if (a >= 'h18 && a <= 'h1A) return (m_rm >> (8*(a-'h18))) & 'hff;
    if (a >= 'h20 && a <= 'h22) return (m_fm >> (8*(a-'h20))) & 'hff;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_rm = 0; m_fm = 0; m_ctrl = 0; m_snap = 0; m_edge = 0; m_ovf = 0;
      live = 1;
    end else begin
      int d, hitv;
      bit hit, ce, co;
      d = int'(din);
      hitv = 0;
      if (m_ctrl & 8)  hitv |= ~m_prev & d & m_rm;
      if (m_ctrl & 16) hitv |= m_prev & ~d & m_fm;
      hit = (hitv & 'hffffff) != 0;
      ce = wr_en && addr == 7 && wdata[3];
      co = wr_en && addr == 7 && wdata[2];
      if (hit && (!m_edge || ce)) m_snap = d;
      m_ovf = (hit && m_edge && !ce) || (m_ovf && !co);
      m_edge = hit || (m_edge && !ce);
      if (wr_en) begin
        if (addr == 'h15) m_ctrl = wdata & 'h1f;
        if (addr >= 'h18 && addr <= 'h1A) m_rm = (m_rm & ~('hff << (8*(addr-'h18)))) | (int'(wdata) << (8*(addr-'h18)));
        if (addr >= 'h20 && addr <= 'h22) m_fm = (m_fm & ~('hff << (8*(addr-'h20)))) | (int'(wdata) << (8*(addr-'h20)));
      end
      m_prev = d;
    end
  end

  always @(negedge clk) if (live && !done) begin
    vecs++;
    if (irq !== m_irq()[0] || rdata !== 8'(m_rd(int'(addr)))) begin
      bad++;
      $display("FAIL model R7/R10 cycle %0d addr %h: irq %b rdata %h, expected irq %0d rdata %h",
               cyc, addr, irq, rdata, m_irq(), m_rd(int'(addr)));
    end
  end

  task automatic step(); @(negedge clk); #2; endtask
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    addr = a; wr_en = 1; wdata = d; step(); wr_en = 0;
  endtask
  task automatic set_din(input logic [23:0] v); din = v; step(); endtask
  task automatic chk_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    addr = a; @(negedge clk); #1;
    vecs++;
    if (rdata !== e) begin bad++; $display("FAIL %s addr %h: got %h expected %h", tag, a, rdata, e); end
    #1;
  endtask
  task automatic chk_irq(input logic e, input string tag);
    vecs++;
    if (irq !== e) begin bad++; $display("FAIL %s irq: got %b expected %b", tag, irq, e); end
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    chk_rd('h14, 8'h00, "R1 status");
    chk_rd('h15, 8'h00, "R1 ctrl");
    chk_rd('h18, 8'h00, "R1 rise mask");
    chk_rd('h10, 8'h00, "R1 snapshot");
    chk_irq(0, "R1");
    chk_rd('h06, 8'h27, "R9 id");

    wr('h18, 8'h01); wr('h19, 8'h80); wr('h1A, 8'h00);
    wr('h22, 8'h40); wr('h15, 8'h1F);
    chk_rd('h15, 8'h1F, "R10 ctrl readback");
    chk_rd('h19, 8'h80, "R10 rise readback");
    chk_rd('h22, 8'h40, "R10 fall readback");
    chk_rd('h3F, 8'h00, "R10 unmapped");
    chk_rd('h07, 8'h00, "R10 clear reads zero");

    addr = 'h14; set_din(24'h000001);
    chk_rd('h14, 8'h05, "R2 rising edge");
    chk_irq(1, "R7 edge irq");
    chk_rd('h10, 8'h01, "R8 snapshot captured");

    set_din(24'h008001);
    chk_rd('h14, 8'h07, "R5 overflow");
    chk_rd('h11, 8'h00, "R8 snapshot held");

    wr('h07, 8'h0C);
    chk_rd('h14, 8'h00, "R6 clear both");
    chk_irq(0, "R6");

    set_din(24'h408001);
    chk_rd('h14, 8'h00, "R4 unarmed rise");
    set_din(24'h008001);
    chk_rd('h14, 8'h05, "R3 falling edge");
    chk_rd('h11, 8'h80, "R8 snapshot mid byte");
    chk_rd('h12, 8'h00, "R8 snapshot top byte");

    wr('h15, 8'h18);
    chk_rd('h14, 8'h01, "R7 edge enable off");
    chk_irq(0, "R7");
    wr('h15, 8'h00);
    chk_irq(0, "R7 ctrl zero");

    wr('h07, 8'h08);
    set_din(24'h008000);
    set_din(24'h008001);
    chk_rd('h14, 8'h00, "R4 rise detection off");

    wr('h15, 8'h1E);
    set_din(24'h008000);
    set_din(24'h008001);
    chk_rd('h14, 8'h01, "R7 edge not enabled for irq");
    chk_irq(0, "R7");
    set_din(24'h000001);
    set_din(24'h008001);
    chk_rd('h14, 8'h07, "R5 overflow drives irq");
    chk_irq(1, "R7 overflow irq");

    set_din(24'h000001);
    din = 24'h008001; addr = 'h07; wr_en = 1; wdata = 8'h0C; step(); wr_en = 0;
    chk_rd('h14, 8'h01, "R6 edge wins over clear");
    chk_rd('h11, 8'h80, "R8 snapshot retaken");

    rst_n = 0; step(); step(); rst_n = 1; step();
    chk_rd('h18, 8'h00, "R1 mask after reset");
    chk_rd('h14, 8'h00, "R1 status after reset");
    chk_irq(0, "R1 irq after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule